// File: doc/BRIEF.md
# Dual-Mode AIS Detector

The detector watches a recovered, unipolar receive bit stream and raises an Alarm Indication Signal flag when the line carries almost nothing but ones. It counts the received bits in consecutive, non-overlapping observation windows and counts the zeros inside each one. At the close of each window it compares the zero count with a threshold. When the count is below the threshold it declares the alarm. When the count meets or exceeds the threshold it clears the alarm.

A standard-select input chooses between two pairs of window length and threshold. With `mode_t1` low (E1) a window is 512 bits and the threshold is 3 zeros. With `mode_t1` high (T1) a window is 8192 bits and the threshold is 9 zeros. The detector runs from the recovered bit clock, and its result does not depend on any loopback setting. When no valid bit clock is present, the surrounding logic drops `enable`, and the detector stays idle with its flag low.

The input is a stream that has a valid qualifier but no ready. The detector never applies back-pressure: it takes every bit presented with `bit_valid` high, and the sender may drop `bit_valid` on any cycle without notice. Bits on cycles where `bit_valid` is low are not counted. A change of `mode_t1`, or `enable` going low, discards the partial window and clears the flag.

Top module: `ais_detector`

## Requirements
- R1: With `mode_t1`=0, a 512-bit window holding 0, 1 or 2 zeros sets `ais` to 1. The flag is visible on the clock edge that takes the window's last bit.
- R2: With `mode_t1`=0, a 512-bit window holding 3 or more zeros sets `ais` to 0 at the window's end.
- R3: With `mode_t1`=1, an 8192-bit window holding 8 or fewer zeros sets `ais` to 1 at the window's end.
- R4: With `mode_t1`=1, an 8192-bit window holding 9 or more zeros sets `ais` to 0 at the window's end.
- R5: Windows follow one another without overlap. `ais` changes only on the edge that accepts the last bit of a window, or on a restart.
- R6: A bit presented with `bit_valid`=0 is neither counted as a bit nor counted as a zero.
- R7: When `enable`=0, `ais` is 0 after the next edge and stays 0. The window that follows starts fresh once `enable` returns to 1.
- R8: When `mode_t1` differs from its value on the previous cycle, `ais` is 0 after the next edge and a fresh window begins. A bit accepted in that cycle is dropped.
- R9: After reset, `ais` is 0.
- R10: The positions of the zeros inside a window do not matter. Any number of zeros above the threshold, up to a window of all zeros, still clears the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_valid | input | 1 | Qualifies `bit_data` for this cycle |
| bit_data | input | 1 | Received unipolar bit (0 = zero on the line) |
| mode_t1 | input | 1 | Line standard: 0 = E1 window, 1 = T1 window |
| enable | input | 1 | Detector run; low while no valid bit clock is present |
| ais | output | 1 | Registered alarm flag |

## Verification
The bench drives each standard with windows that hold exactly one zero fewer than the threshold and exactly the threshold. A design whose comparison is off by one would declare or clear on the wrong window. It holds the flag across a window and checks that the flag stays unchanged until the window's last bit, which catches a design that decides early or on a sliding count. It restarts the detector partway through a window, through `enable` and through a change of standard. A design that kept its partial count would close the window early and raise the flag too soon. Zeros sent on cycles where `bit_valid` is low test the qualifier, and random gaps and random zero positions test R10.

// File: rtl/ais_pkg.sv
package ais_pkg;
  typedef enum logic {STD_E1 = 1'b0, STD_T1 = 1'b1} line_std_e;

  localparam int unsigned E1_WIN_BITS = 512;
  localparam int unsigned E1_MIN_ZEROS = 3;
  localparam int unsigned T1_WIN_BITS = 8192;
  localparam int unsigned T1_MIN_ZEROS = 9;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/ais_bit_window.sv
module ais_bit_window #(
  parameter int unsigned WIN_A = 512,
  parameter int unsigned WIN_B = 8192
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic sel_b,
  input  logic bit_stb,
  output logic win_end
);
  localparam int unsigned WMAX = ais_pkg::max_u(WIN_A, WIN_B);
  localparam int unsigned CW = (WMAX > 1) ? $clog2(WMAX) : 1;
  localparam logic [CW-1:0] LAST_A = CW'(WIN_A - 1);
  localparam logic [CW-1:0] LAST_B = CW'(WIN_B - 1);

  logic [CW-1:0] pos_q;
  logic [CW-1:0] last_pos;

  assign last_pos = sel_b ? LAST_B : LAST_A;
  assign win_end  = bit_stb && !restart && (pos_q == last_pos);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
    end else if (restart || win_end) begin
      pos_q <= '0;
    end else if (bit_stb) begin
      pos_q <= pos_q + CW'(1);
    end
  end
endmodule

// File: rtl/ais_zero_tally.sv
module ais_zero_tally #(
  parameter int unsigned THR_A = 3,
  parameter int unsigned THR_B = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic sel_b,
  input  logic bit_stb,
  input  logic bit_zero,
  input  logic win_end,
  output logic thr_met
);
  localparam int unsigned TMAX = ais_pkg::max_u(THR_A, THR_B);
  localparam int unsigned ZW = $clog2(TMAX + 1);
  localparam logic [ZW-1:0] LIM_A = ZW'(THR_A);
  localparam logic [ZW-1:0] LIM_B = ZW'(THR_B);

  logic [ZW-1:0] zcnt_q;
  logic [ZW-1:0] zcnt_nx;
  logic [ZW-1:0] limit;

  assign limit = sel_b ? LIM_B : LIM_A;

  always_comb begin
    zcnt_nx = zcnt_q;
    if (bit_stb && bit_zero && (zcnt_q < limit)) begin
      zcnt_nx = zcnt_q + ZW'(1);
    end
  end

  assign thr_met = (zcnt_nx >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zcnt_q <= '0;
    end else if (restart || win_end) begin
      zcnt_q <= '0;
    end else begin
      zcnt_q <= zcnt_nx;
    end
  end
endmodule

// File: rtl/ais_flag.sv
module ais_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic win_end,
  input  logic thr_met,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
    end else if (restart) begin
      flag <= 1'b0;
    end else if (win_end) begin
      flag <= !thr_met;
    end
  end
endmodule

// File: rtl/ais_detector.sv
module ais_detector #(
  parameter int unsigned E1_WIN  = ais_pkg::E1_WIN_BITS,
  parameter int unsigned E1_THR  = ais_pkg::E1_MIN_ZEROS,
  parameter int unsigned T1_WIN  = ais_pkg::T1_WIN_BITS,
  parameter int unsigned T1_THR  = ais_pkg::T1_MIN_ZEROS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_valid,
  input  logic bit_data,
  input  logic mode_t1,
  input  logic enable,
  output logic ais
);
  import ais_pkg::*;

  line_std_e std_q;
  line_std_e std_in;
  logic      restart;
  logic      bit_stb;
  logic      win_end;
  logic      thr_met;

  assign std_in  = mode_t1 ? STD_T1 : STD_E1;
  assign restart = !enable || (std_in != std_q);
  assign bit_stb = bit_valid && enable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      std_q <= STD_E1;
    end else begin
      std_q <= std_in;
    end
  end

  ais_bit_window #(.WIN_A(E1_WIN), .WIN_B(T1_WIN)) u_window (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .sel_b(std_q == STD_T1), .bit_stb(bit_stb), .win_end(win_end)
  );

  ais_zero_tally #(.THR_A(E1_THR), .THR_B(T1_THR)) u_tally (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .sel_b(std_q == STD_T1), .bit_stb(bit_stb), .bit_zero(!bit_data),
    .win_end(win_end), .thr_met(thr_met)
  );

  ais_flag u_flag (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .win_end(win_end), .thr_met(thr_met), .flag(ais)
  );
endmodule

// File: rtl/ais_detector_chk.sv
module ais_detector_chk #(
  parameter int unsigned E1_WIN = 512,
  parameter int unsigned T1_WIN = 8192
) (
  input logic clk,
  input logic rst_n,
  input logic bit_valid,
  input logic bit_data,
  input logic mode_t1,
  input logic enable,
  input logic ais
);
  localparam int unsigned CW = $clog2((E1_WIN > T1_WIN ? E1_WIN : T1_WIN) + 1);

  logic          prev_mode;
  logic [CW-1:0] seen;
  logic          bnd_q;
  logic          rst_q;
  logic          ais_q;
  logic          chk_restart;
  logic          chk_bnd;

  assign chk_restart = !enable || (mode_t1 != prev_mode);
  assign chk_bnd = !chk_restart && bit_valid &&
                   (seen == CW'((prev_mode ? T1_WIN : E1_WIN) - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_mode <= 1'b0;
      seen      <= '0;
      bnd_q     <= 1'b0;
      rst_q     <= 1'b0;
      ais_q     <= 1'b0;
    end else begin
      prev_mode <= mode_t1;
      bnd_q     <= chk_bnd;
      rst_q     <= chk_restart;
      ais_q     <= ais;
      if (chk_restart || chk_bnd) seen <= '0;
      else if (bit_valid) seen <= seen + CW'(1);
    end
  end

  AST_CHANGE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (ais != ais_q) |-> (bnd_q || rst_q)); // R5
  AST_RISE_AT_WINDOW_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ais) |-> bnd_q); // R1
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !ais); // R7
  AST_MODE_SWITCH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_t1 != prev_mode) |=> !ais); // R8
  AST_FLAG_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(ais)); // R9
endmodule

bind ais_detector ais_detector_chk #(.E1_WIN(E1_WIN), .T1_WIN(T1_WIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_data(bit_data),
  .mode_t1(mode_t1), .enable(enable), .ais(ais)
);

// File: tb/ais_detector_tb.sv
module ais_detector_tb;
  localparam int E1W = 512;
  localparam int E1T = 3;
  localparam int T1W = 8192;
  localparam int T1T = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_valid = 1'b0;
  logic bit_data = 1'b1;
  logic mode_t1 = 1'b0;
  logic enable = 1'b0;
  logic ais;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [T1W-1:0] pat;

  always #5 clk = ~clk;

  ais_detector u_dut (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_data(bit_data),
    .mode_t1(mode_t1), .enable(enable), .ais(ais)
  );

  function automatic logic exp_flag(input int zeros, input int thr);
    return (zeros < thr);
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: ais=%0b expected %0b", req, act, exp);
    end
  endtask

  task automatic make_pat(input int nbits, input int nzero);
    int cnt = 0;
    pat = '1;
    while (cnt < nzero) begin
      int idx = int'($urandom % nbits);
      if (pat[idx]) begin
        pat[idx] = 1'b0;
        cnt++;
      end
    end
  endtask

  // Sends bits [first, first+n) of pat with random invalid gaps whose data is 0.
  task automatic send(input int first, input int n, input bit gaps);
    for (int i = first; i < first + n; i++) begin
      if (gaps && ($urandom % 8 == 0)) begin
        @(negedge clk);
        bit_valid = 1'b0;
        bit_data  = 1'b0;
      end
      @(negedge clk);
      bit_valid = 1'b1;
      bit_data  = pat[i];
    end
    @(negedge clk);
    bit_valid = 1'b0;
    bit_data  = 1'b1;
  endtask

  task automatic window(input string req, input int nbits, input int nzero, input int thr);
    make_pat(nbits, nzero);
    send(0, nbits, 1'b1);
    check(req, ais, exp_flag(nzero, thr));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: ais=%0b expected completion", ais);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    check("R9", ais, 1'b0);
    rst_n = 1'b1;
    enable = 1'b1;
    @(negedge clk);
    check("R9", ais, 1'b0);

    // E1 directed edges
    window("R1", E1W, E1T - 1, E1T);
    window("R2", E1W, E1T, E1T);
    window("R1", E1W, 0, E1T);
    // R5: flag held until the last bit of the next window
    make_pat(E1W, E1T);
    send(0, E1W - 1, 1'b1);
    check("R5", ais, 1'b1);
    send(E1W - 1, 1, 1'b0);
    check("R5", ais, exp_flag(E1T, E1T));
    // R10: full-zero window clears
    pat = '0;
    window("R1", E1W, 0, E1T);
    pat = '0;
    send(0, E1W, 1'b1);
    check("R10", ais, 1'b0);
    // R6: zeros on invalid cycles do not count
    make_pat(E1W, E1T - 1);
    for (int i = 0; i < E1W; i++) begin
      @(negedge clk);
      bit_valid = 1'b0;
      bit_data  = 1'b0;
      @(negedge clk);
      bit_valid = 1'b1;
      bit_data  = pat[i];
    end
    @(negedge clk);
    bit_valid = 1'b0;
    bit_data  = 1'b1;
    check("R6", ais, 1'b1);
    // E1 random windows
    for (int k = 0; k < 20; k++) begin
      int z = int'($urandom % 7);
      window((z < E1T) ? "R1" : "R10", E1W, z, E1T);
    end

    // R7: enable low clears and restarts window
    window("R1", E1W, 0, E1T);
    enable = 1'b0;
    @(negedge clk);
    check("R7", ais, 1'b0);
    enable = 1'b1;
    make_pat(300, 0);
    send(0, 300, 1'b0);
    enable = 1'b0;
    @(negedge clk);
    enable = 1'b1;
    pat = '1;
    pat[E1W-1] = 1'b0; pat[E1W-2] = 1'b0; pat[E1W-3] = 1'b0;
    send(0, 300, 1'b0);
    check("R7", ais, 1'b0);
    send(300, E1W - 300, 1'b0);
    check("R7", ais, 1'b0);

    // R8: mode change mid-window clears and restarts
    window("R1", E1W, 1, E1T);
    mode_t1 = 1'b1;
    @(negedge clk);
    check("R8", ais, 1'b0);
    mode_t1 = 1'b0;
    @(negedge clk);
    make_pat(300, 0);
    send(0, 300, 1'b0);
    mode_t1 = 1'b1;
    @(negedge clk);
    mode_t1 = 1'b0;
    @(negedge clk);
    pat = '1;
    pat[E1W-1] = 1'b0; pat[E1W-2] = 1'b0; pat[E1W-3] = 1'b0;
    send(0, 300, 1'b0);
    check("R8", ais, 1'b0);
    send(300, E1W - 300, 1'b0);
    check("R8", ais, 1'b0);

    // T1
    mode_t1 = 1'b1;
    @(negedge clk);
    window("R3", T1W, T1T - 1, T1T);
    window("R4", T1W, T1T, T1T);
    window("R3", T1W, 0, T1T);
    make_pat(T1W, 20);
    send(0, T1W - 1, 1'b1);
    check("R5", ais, 1'b1);
    send(T1W - 1, 1, 1'b0);
    check("R4", ais, 1'b0);
    for (int k = 0; k < 3; k++) begin
      int z = 6 + int'($urandom % 6);
      window((z < T1T) ? "R3" : "R4", T1W, z, T1T);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule